// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one counting channel of an interval timer. A down-counter of parameterized width (16 bits by default) decrements on cycles where a count-clock enable is high. The enable is derived from the system clock outside the block. A register front end, which is not part of this block, supplies two things through write strobes:

- a control setting: an operating mode and a binary/decimal select;
- a start value.

The channel drives a single output level from the mode and the count. It has six behaviours:

- terminal-count interrupt;
- retriggerable one-shot;
- rate generator;
- square wave;
- strobe started by software;
- strobe started by a gate edge.

A gate input either suspends counting or starts and restarts it, depending on the mode. The live count is presented on a port. A pending flag shows that a written start value has not yet reached the counting element.

In decimal mode the counter runs as four packed decimal digits and wraps from 0000 to 9999. A start value of zero always stands for the full range: 65536 counts in binary and 10000 in decimal.

Top module: `icc_channel`

## Requirements
- R1: During and after reset, before any write, `count_o` is 0, `out_o` is 1 and `start_pending_o` is 0.
- R2: A control write (`wr_ctrl`) takes effect on the next clock. `out_o` becomes 0 if `ctrl_mode` is 000 and 1 otherwise. `start_pending_o` becomes 0, and counting stops until a new start value is loaded.
- R3: A start write (`wr_start`) sets `start_pending_o` on the next clock. The flag clears on the count tick that copies the start value into the counter. In gate-suspended modes that is the first count tick after the write. In gate-triggered modes it is the first count tick after a rising gate edge. In mode 000 the start write also drives `out_o` to 0.
- R4: Mode 000 (interrupt on terminal count): `out_o` stays 0 from the start write until the count steps from 1 to 0, then stays 1.
- R5: Mode 001 (one-shot): a loading tick drives `out_o` to 0. `out_o` returns to 1 when the count steps from 1 to 0. A rising gate edge during the count reloads the start value, which stretches the pulse.
- R6: Mode x10 (rate generator): `out_o` is 0 for exactly one count tick, while the count equals 1. The next tick reloads the start value and raises `out_o`, so the period is N ticks.
- R7: Mode x11 (square wave): the counter loads N with bit 0 cleared and steps by 2, and `out_o` toggles at the end of each half. For even N both halves last N/2 ticks. For odd N the high half lasts (N+1)/2 ticks and the low half (N-1)/2 ticks.
- R8: Modes 100 and 101 (strobes): `out_o` stays 1 except for one count tick after the count steps from 1 to 0. Mode 100 starts on the start write. Mode 101 starts on a rising gate edge.
- R9: In modes 000, x10, x11 and 100, a count tick with `gate` low leaves `count_o` and `out_o` unchanged. The exception is a tick that loads a pending start value.
- R10: `count_o` changes only on clocks where `cnt_en` is high. A start value of 0 runs the full range, so the first decrement gives FFFFh in binary.
- R11: With `ctrl_bcd` = 1 every nibble of `count_o` stays within 0..9 while the channel runs, and the count wraps from 0000 to 9999.
- R12: Mode codes 110 and 111 behave exactly like 010 and 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-clock enable, one tick per high cycle |
| gate | input | 1 | Gate level, synchronous to clk |
| wr_ctrl | input | 1 | Control write strobe |
| ctrl_mode | input | 3 | Operating mode code |
| ctrl_bcd | input | 1 | 1 selects four-digit decimal counting |
| wr_start | input | 1 | Start value write strobe |
| start_val | input | CNT_W | Start value, 0 meaning full range |
| count_o | output | CNT_W | Live count |
| out_o | output | 1 | Channel output level |
| start_pending_o | output | 1 | Start value written but not yet loaded |

## Verification
The assertions assume the following about the inputs:

- `wr_ctrl` and `wr_start` never arrive in the same clock;
- `gate` is already synchronous to `clk`;
- in decimal mode every start value holds valid digits, so the nibble-range property is meaningful;
- square-wave start values of 1 and 3 are treated as outside the supported range.

The stimulus drives each strobe for a single clock on the falling edge and writes only decimal-clean start values while decimal mode is selected. It uses square-wave start values of 4, 5 and 6 only. The per-clock reference model derives every expected count and output level with integer arithmetic from these same rules.

// File: rtl/icc_pkg.sv
package icc_pkg;

   typedef enum logic [2:0] {
      MD_TCINT   = 3'd0,
      MD_ONESHOT = 3'd1,
      MD_RATE    = 3'd2,
      MD_SQUARE  = 3'd3,
      MD_SWSTB   = 3'd4,
      MD_HWSTB   = 3'd5
   } mode_e;

   // codes with bit 1 set alias to rate / square regardless of bit 2
   function automatic mode_e decode_mode(input logic [2:0] code);
      if (code[1]) return code[0] ? MD_SQUARE : MD_RATE;
      return mode_e'(code);
   endfunction

   function automatic logic edge_started(input mode_e m);
      return (m == MD_ONESHOT) || (m == MD_HWSTB);
   endfunction

endpackage

// File: rtl/icc_step.sv
module icc_step #(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [CNT_W-1:0] val_i,
   input  logic             bcd_i,
   input  logic             by2_i,
   output logic [CNT_W-1:0] val_o
);
   localparam int DIGITS = CNT_W / 4;

   logic [CNT_W-1:0] bin_res;
   assign bin_res = val_i - (by2_i ? CNT_W'(2) : CNT_W'(1));

   generate
      if (BCD_EN) begin : g_dec
         logic [1:0]       take [DIGITS];
         logic [CNT_W-1:0] dec_res;
         assign take[0] = by2_i ? 2'd2 : 2'd1;
         for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            logic [4:0] diff;
            assign diff = {1'b0, val_i[4*d +: 4]} - {3'd0, take[d]};
            assign dec_res[4*d +: 4] = diff[4] ? 4'(diff + 5'd10) : diff[3:0];
            if (d < DIGITS - 1) begin : g_brw
               assign take[d+1] = {1'b0, diff[4]};
            end
         end
         assign val_o = bcd_i ? dec_res : bin_res;
      end else begin : g_bin
         logic g_unused;
         assign g_unused = bcd_i;
         assign val_o    = bin_res;
      end
   endgenerate
endmodule

// File: rtl/icc_trig.sv
module icc_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   input  logic clear_i,
   input  logic consume_i,
   output logic trig_o
);
   logic gate_q;
   logic held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         held_q <= 1'b0;
      end else begin
         gate_q <= gate_i;
         if (clear_i) held_q <= 1'b0;
         else         held_q <= (held_q & ~consume_i) | (gate_i & ~gate_q);
      end
   end

   assign trig_o = held_q;
endmodule

// File: rtl/icc_channel.sv
module icc_channel #(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             gate,
   input  logic             wr_ctrl,
   input  logic [2:0]       ctrl_mode,
   input  logic             ctrl_bcd,
   input  logic             wr_start,
   input  logic [CNT_W-1:0] start_val,
   output logic [CNT_W-1:0] count_o,
   output logic             out_o,
   output logic             start_pending_o
);
   import icc_pkg::*;

   generate
      if ((CNT_W % 4) != 0 || CNT_W < 8) begin : g_bad_width
         $error("icc_channel: CNT_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   mode_e            mode_q;
   logic             bcd_q;
   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] cnt_q;
   logic             out_q, pend_q, arm_q, run_q;

   logic             trig, by_edge, load_now, step_on, by2, half_end;
   logic             is0, is1, is2, quiet;
   logic [CNT_W-1:0] cnt_dec, load_val;

   assign by_edge  = edge_started(mode_q);
   assign by2      = (mode_q == MD_SQUARE);
   assign quiet    = cnt_en && !wr_ctrl && !wr_start;
   assign load_now = quiet && (by_edge ? (trig && arm_q) : pend_q);
   assign step_on  = quiet && !load_now && run_q && (by_edge || gate);
   assign load_val = by2 ? {start_q[CNT_W-1:1], 1'b0} : start_q;
   assign is0      = (cnt_q == '0);
   assign is1      = (cnt_q == ONE);
   assign is2      = (cnt_q == TWO);
   // an odd start stretches the high half by one tick: it runs down to 0
   assign half_end = (out_q && start_q[0]) ? is0 : is2;

   icc_trig u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_i    (gate),
      .clear_i   (wr_ctrl | wr_start),
      .consume_i (load_now & by_edge),
      .trig_o    (trig)
   );

   icc_step #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_step (
      .val_i (cnt_q),
      .bcd_i (bcd_q),
      .by2_i (by2),
      .val_o (cnt_dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MD_TCINT;
         bcd_q   <= 1'b0;
         start_q <= '0;
         cnt_q   <= '0;
         out_q   <= 1'b1;
         pend_q  <= 1'b0;
         arm_q   <= 1'b0;
         run_q   <= 1'b0;
      end else if (wr_ctrl) begin
         mode_q <= decode_mode(ctrl_mode);
         bcd_q  <= ctrl_bcd;
         out_q  <= (ctrl_mode != 3'b000);
         pend_q <= 1'b0;
         arm_q  <= 1'b0;
         run_q  <= 1'b0;
      end else if (wr_start) begin
         start_q <= start_val;
         pend_q  <= 1'b1;
         arm_q   <= 1'b1;
         if (mode_q == MD_TCINT) out_q <= 1'b0;
      end else if (load_now) begin
         cnt_q  <= load_val;
         pend_q <= 1'b0;
         run_q  <= 1'b1;
         unique case (mode_q)
            MD_ONESHOT:         out_q <= 1'b0;
            MD_RATE, MD_SQUARE: out_q <= 1'b1;
            default:            out_q <= out_q;
         endcase
      end else if (step_on) begin
         unique case (mode_q)
            MD_TCINT, MD_ONESHOT: begin
               cnt_q <= cnt_dec;
               if (is1) out_q <= 1'b1;
            end
            MD_RATE: begin
               if (is1) begin
                  cnt_q <= start_q;
                  out_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_dec;
                  out_q <= !is2;
               end
            end
            MD_SQUARE: begin
               if (half_end) begin
                  cnt_q <= load_val;
                  out_q <= !out_q;
               end else begin
                  cnt_q <= cnt_dec;
               end
            end
            default: begin
               cnt_q <= cnt_dec;
               out_q <= !is1;
            end
         endcase
      end
   end

   assign count_o         = cnt_q;
   assign out_o           = out_q;
   assign start_pending_o = pend_q;
endmodule

// File: rtl/icc_channel_chk.sv
module icc_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             gate,
   input logic             wr_ctrl,
   input logic [2:0]       ctrl_mode,
   input logic             wr_start,
   input logic [CNT_W-1:0] count_o,
   input logic             out_o,
   input logic             start_pending_o,
   input logic [2:0]       mode_q,
   input logic             bcd_q,
   input logic             run_q
);
   localparam int DIGITS = CNT_W / 4;

   function automatic logic digits_ok(input logic [CNT_W-1:0] v);
      for (int d = 0; d < DIGITS; d++)
         if (v[4*d +: 4] > 4'd9) return 1'b0;
      return 1'b1;
   endfunction

   logic gated_mode;
   assign gated_mode = (mode_q != 3'd1) && (mode_q != 3'd5);

   // R10
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(count_o));

   // R2
   ctrl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (out_o == ($past(ctrl_mode) != 3'b000)));

   // R2
   ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !start_pending_o);

   // R3
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && !wr_ctrl) |=> start_pending_o);

   // R3
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_pending_o) |-> ($past(cnt_en) || $past(wr_ctrl)));

   // R9
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !gate && gated_mode && !start_pending_o && !wr_ctrl && !wr_start)
      |=> ($stable(count_o) && $stable(out_o)));

   // R11
   bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcd_q && run_q) |-> digits_ok(count_o));
endmodule

bind icc_channel icc_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cnt_en          (cnt_en),
   .gate            (gate),
   .wr_ctrl         (wr_ctrl),
   .ctrl_mode       (ctrl_mode),
   .wr_start        (wr_start),
   .count_o         (count_o),
   .out_o           (out_o),
   .start_pending_o (start_pending_o),
   .mode_q          (mode_q),
   .bcd_q           (bcd_q),
   .run_q           (run_q)
);

// File: tb/icc_channel_bench.sv
module icc_channel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        gate = 1'b1;
   logic        wr_ctrl = 1'b0;
   logic [2:0]  ctrl_mode = 3'd0;
   logic        ctrl_bcd = 1'b0;
   logic        wr_start = 1'b0;
   logic [15:0] start_val = 16'd0;
   logic [15:0] count_o;
   logic        out_o;
   logic        start_pending_o;

   int    n_checks = 0;
   int    n_fails  = 0;
   int    en_div   = 1;
   int    div_cnt  = 0;
   int    cycles   = 0;
   bit    done     = 1'b0;
   string tag      = "R1";

   icc_channel u_icc_channel (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
      .wr_ctrl(wr_ctrl), .ctrl_mode(ctrl_mode), .ctrl_bcd(ctrl_bcd),
      .wr_start(wr_start), .start_val(start_val),
      .count_o(count_o), .out_o(out_o), .start_pending_o(start_pending_o)
   );

   always #5 clk = ~clk;

   function automatic int from_bcd(input logic [15:0] b);
      int v = 0;
      for (int d = 3; d >= 0; d--) v = v * 10 + int'(b[4*d +: 4]);
      return v;
   endfunction

   function automatic logic [15:0] to_bcd(input int v);
      logic [15:0] b = '0;
      int r = v;
      for (int d = 0; d < 4; d++) begin
         b[4*d +: 4] = 4'(r % 10);
         r = r / 10;
      end
      return b;
   endfunction

   // reference model state
   logic [15:0] m_cnt, m_start;
   int          m_mode;
   bit          m_bcd, m_out, m_pend, m_arm, m_run, m_trig, m_gq;

   always @(posedge clk) begin : model
      int  lim, sv, cv, ldv, endc;
      bit  rise, trigm, consumed, touched;
      if (!rst_n) begin
         m_cnt = '0; m_start = '0; m_mode = 0; m_bcd = 0; m_out = 1;
         m_pend = 0; m_arm = 0; m_run = 0; m_trig = 0; m_gq = 0;
      end else begin
         rise  = gate && !m_gq;
         m_gq  = gate;
         trigm = (m_mode == 1) || (m_mode == 5);
         lim   = m_bcd ? 10000 : 65536;
         sv    = m_bcd ? from_bcd(m_start) : int'(m_start);
         cv    = m_bcd ? from_bcd(m_cnt) : int'(m_cnt);
         ldv   = (m_mode == 3) ? sv - (sv % 2) : sv;
         if (wr_ctrl) begin
            m_mode = ctrl_mode[1] ? (ctrl_mode[0] ? 3 : 2) : int'(ctrl_mode);
            m_bcd = ctrl_bcd; m_out = (ctrl_mode != 3'd0);
            m_pend = 0; m_arm = 0; m_run = 0; m_trig = 0;
         end else if (wr_start) begin
            m_start = start_val; m_pend = 1; m_arm = 1; m_trig = 0;
            if (m_mode == 0) m_out = 0;
         end else begin
            consumed = 0; touched = 0;
            if (cnt_en && (trigm ? (m_trig && m_arm) : m_pend)) begin
               cv = ldv; m_pend = 0; m_run = 1; consumed = trigm; touched = 1;
               if (m_mode == 1) m_out = 0;
               if (m_mode == 2 || m_mode == 3) m_out = 1;
            end else if (cnt_en && m_run && (trigm || gate)) begin
               touched = 1;
               case (m_mode)
                  0, 1: begin
                     if (cv == 1) m_out = 1;
                     cv = (cv - 1 + lim) % lim;
                  end
                  2: begin
                     if (cv == 1) begin cv = sv; m_out = 1; end
                     else begin m_out = (cv != 2); cv = (cv - 1 + lim) % lim; end
                  end
                  3: begin
                     endc = (m_out && (sv % 2 == 1)) ? 0 : 2;
                     if (cv == endc) begin cv = ldv; m_out = !m_out; end
                     else cv = (cv - 2 + lim) % lim;
                  end
                  default: begin
                     m_out = (cv != 1);
                     cv = (cv - 1 + lim) % lim;
                  end
               endcase
            end
            if (touched) m_cnt = m_bcd ? to_bcd(cv) : 16'(cv);
            m_trig = (m_trig && !consumed) || rise;
         end
      end
   end

   // count-clock enable divider
   always @(negedge clk) begin
      cnt_en  = (div_cnt == 0);
      div_cnt = (div_cnt + 1 >= en_div) ? 0 : div_cnt + 1;
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (count_o !== m_cnt || out_o !== m_out || start_pending_o !== m_pend) begin
            n_fails++;
            $display("FAIL %s t=%0t count/out/pend actual %h/%b/%b expected %h/%b/%b",
                     tag, $time, count_o, out_o, start_pending_o, m_cnt, m_out, m_pend);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_fails++;
         $display("FAIL watchdog expired during %s", tag);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic prog(input logic [2:0] md, input logic bcd);
      @(negedge clk);
      wr_ctrl = 1'b1; ctrl_mode = md; ctrl_bcd = bcd;
      @(negedge clk);
      wr_ctrl = 1'b0;
   endtask

   task automatic load(input logic [15:0] v);
      @(negedge clk);
      wr_start = 1'b1; start_val = v;
      @(negedge clk);
      wr_start = 1'b0;
   endtask

   task automatic pulse_gate();
      @(negedge clk); gate = 1'b0;
      @(negedge clk); gate = 1'b1;
   endtask

   initial begin
      run(3);
      // R1: reset state observed while reset is held
      n_checks++;
      if (count_o !== 16'd0 || out_o !== 1'b1 || start_pending_o !== 1'b0) begin
         n_fails++;
         $display("FAIL R1 reset actual %h/%b/%b expected 0000/1/0",
                  count_o, out_o, start_pending_o);
      end
      rst_n = 1'b1;
      run(4);

      tag = "R4 R9 R3";
      prog(3'b000, 1'b0); load(16'd5); run(4);
      gate = 1'b0; run(5); gate = 1'b1; run(10);

      tag = "R5";
      prog(3'b001, 1'b0); load(16'd4); run(3);
      pulse_gate(); run(3); pulse_gate(); run(10);

      tag = "R6 R9";
      prog(3'b010, 1'b0); load(16'd3); run(10);
      gate = 1'b0; run(4); gate = 1'b1; run(10);

      tag = "R7";
      en_div = 2;
      prog(3'b011, 1'b0); load(16'd6); run(30);
      load(16'd5); run(40);
      en_div = 1;

      tag = "R8";
      prog(3'b100, 1'b0); load(16'd4); run(10);
      prog(3'b101, 1'b0); load(16'd3); run(3);
      pulse_gate(); run(10);

      tag = "R11";
      prog(3'b010, 1'b1); load(16'h0012); run(30);
      prog(3'b000, 1'b1); load(16'h0000); run(10);

      tag = "R12";
      prog(3'b110, 1'b0); load(16'd4); run(12);
      prog(3'b111, 1'b0); load(16'd4); run(12);

      tag = "R10";
      en_div = 3;
      prog(3'b000, 1'b0); load(16'd0); run(15);
      en_div = 1;

      tag = "R2";
      prog(3'b001, 1'b0); run(5);
      prog(3'b000, 1'b0); run(5);

      tag = "R3";
      prog(3'b101, 1'b0); load(16'd7); run(5);
      pulse_gate(); run(12);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule